// File: doc/BRIEF.md
# Multi-Root Hot-Removal Sequencer

This block runs the removal of an adapter from one switch slot that several virtual hierarchies share. One physical slot controller, owned by the multi-root manager, sits above one virtual slot controller per plane, each owned by that plane's single-root software. An attention button press is reported to the multi-root manager. Once the manager acknowledges, a removal event goes out to every plane enabled on the slot. The block then collects a completion from each of those planes. When all have reported, the manager is told, and only then is a power-off command accepted. Accepting it drops slot power and turns the indicator dark.

The software register paths are modelled as level requests and single-cycle acknowledge pulses. A plane that stays silent past a programmable cycle limit raises its own error bit. The sequence then halts until the manager either aborts the removal, which restores the slot to normal service, or forces completion, which lets power-off go ahead.

Top module: `hot_removal_seq`

## Requirements
- R1: After reset the slot is powered, the indicator code is 2'b01 (steady on), and the outputs for manager notification, plane requests, all-done, plane errors and busy are all zero.
- R2: A button press while idle raises the manager notification and sets the indicator code to 2'b10 (blinking) on the next cycle, with busy high.
- R3: A manager acknowledge while notification is raised clears the notification on the next cycle and raises the virtual removal request of exactly the planes whose enable bit is 1 (bit i is plane i). Disabled planes get no request.
- R4: A completion pulse from a plane with a pending request clears that plane's request on the next cycle and leaves the other planes' requests unchanged.
- R5: The all-done indication to the manager rises one cycle after the last pending request has cleared. With no plane enabled, it rises one cycle after the requests would have been issued.
- R6: A power-off command is acted on only while all-done is shown. Slot power then falls and the indicator code becomes 2'b00 on the next cycle. The slot stays off until reset, and a power-off command at any other time changes nothing.
- R7: A button press while a removal is already under way changes no output.
- R8: When the cycle count since the requests were issued reaches the timeout limit while a plane is still pending, the error bit of each still-pending plane is set one cycle later. The sequence then holds, ignoring plane completions, until abort or force.
- R9: An abort while halted clears all requests and error bits and returns to the idle state with the slot powered and the indicator code 2'b01. A later button press starts a new removal.
- R10: A force while halted clears all requests and shows all-done on the next cycle, keeping the error bits. A following power-off command removes slot power.
- R11: The indicator code is 2'b01 while idle, 2'b10 at every step of a removal in progress, and 2'b00 whenever slot power is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn_press_i | input | 1 | Attention button press pulse |
| plane_en_i | input | NUM_PLANES | Planes enabled on this slot |
| tmo_limit_i | input | TMO_W | Completion timeout in cycles |
| mgr_notify_o | output | 1 | Removal request reported to the multi-root manager |
| mgr_notify_ack_i | input | 1 | Manager acknowledge, starts the per-plane events |
| vevt_req_o | output | NUM_PLANES | Per-plane virtual removal event pending |
| vevt_done_i | input | NUM_PLANES | Per-plane completion pulse from plane software |
| mgr_all_done_o | output | 1 | All enabled planes have completed |
| mgr_power_off_i | input | 1 | Manager command to remove slot power |
| mgr_abort_i | input | 1 | Manager abort of a halted removal |
| mgr_force_i | input | 1 | Manager force-completion of a halted removal |
| plane_err_o | output | NUM_PLANES | Per-plane timeout error |
| slot_pwr_o | output | 1 | Slot power enable |
| led_o | output | 2 | Indicator code: 00 off, 01 on, 10 blinking |
| busy_o | output | 1 | Removal in progress |

## Verification
Every control input acts on registered state, so each single-step response (notification, requests, power and indicator) is due exactly one clock edge after the input pulse. The all-done indication comes one edge after the last request clears. The error bits come one edge after the cycle on which the count since issue equals the limit. The bench drives each pulse across one edge and advances a counted number of edges. It then queues the expected output set at the following falling edge, and the monitor compares it there. Each check lands on the first cycle where the result is due, and on the cycle just before it for the boundaries.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_NOTIFY = 3'd1,
    PH_FANOUT = 3'd2,
    PH_STALL  = 3'd3,
    PH_READY  = 3'd4,
    PH_OFF    = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    IND_DARK  = 2'b00,
    IND_STEDY = 2'b01,
    IND_BLINK = 2'b10
  } ind_e;

endpackage

// File: rtl/hrs_vplane.sv
module hrs_vplane (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic start_i,
  input  logic accept_i,
  input  logic done_i,
  input  logic expire_i,
  input  logic clr_pend_i,
  input  logic clr_err_i,
  output logic pend_o,
  output logic err_o
);

  logic pend_q, pend_d, pend_ce;
  logic err_q, err_d, err_ce;

  always_comb begin
    pend_d  = pend_q;
    pend_ce = 1'b0;
    if (start_i) begin
      pend_d  = enable_i;
      pend_ce = 1'b1;
    end else if (clr_pend_i) begin
      pend_d  = 1'b0;
      pend_ce = 1'b1;
    end else if (accept_i && done_i && pend_q) begin
      pend_d  = 1'b0;
      pend_ce = 1'b1;
    end
  end

  always_comb begin
    err_d  = err_q;
    err_ce = 1'b0;
    if (start_i || clr_err_i) begin
      err_d  = 1'b0;
      err_ce = 1'b1;
    end else if (expire_i && pend_q) begin
      err_d  = 1'b1;
      err_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_ce) begin
      err_q <= err_d;
    end
  end

  assign pend_o = pend_q;
  assign err_o  = err_q;

  // R4: an accepted completion retires the pending request
  p_done_retires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && accept_i && done_i && !start_i && !clr_pend_i) |=> !pend_q);

  // R8: an error bit only rises after a timeout expiry while pending
  p_err_needs_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(expire_i) && $past(pend_q)));

endmodule

// File: rtl/hrs_timer.sv
module hrs_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             any_pend_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_d  = '0;
      cnt_ce = (cnt_q != '0);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i && any_pend_i && (cnt_q == limit_i);

  // R8: the count restarts from zero each time the wait phase is entered
  p_count_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !$past(run_i)) |-> (cnt_q == '0));

endmodule

// File: rtl/hrs_phys_fsm.sv
module hrs_phys_fsm
  import hrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press_i,
  input  logic       ack_i,
  input  logic       all_clear_i,
  input  logic       expire_i,
  input  logic       pwr_cmd_i,
  input  logic       abort_i,
  input  logic       force_i,
  output logic       start_o,
  output logic       fanout_o,
  output logic       clr_pend_o,
  output logic       clr_err_o,
  output logic       notify_o,
  output logic       all_done_o,
  output logic       slot_pwr_o,
  output logic [1:0] led_o,
  output logic       busy_o
);

  phase_e ph_q, ph_d;
  logic   ph_ce;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (press_i) ph_d = PH_NOTIFY;
      PH_NOTIFY: if (ack_i) ph_d = PH_FANOUT;
      PH_FANOUT: begin
        if (all_clear_i)   ph_d = PH_READY;
        else if (expire_i) ph_d = PH_STALL;
      end
      PH_STALL: begin
        if (abort_i)      ph_d = PH_IDLE;
        else if (force_i) ph_d = PH_READY;
      end
      PH_READY:  if (pwr_cmd_i) ph_d = PH_OFF;
      PH_OFF:    ph_d = PH_OFF;
      default:   ph_d = PH_IDLE;
    endcase
    ph_ce = (ph_d != ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else if (ph_ce) begin
      ph_q <= ph_d;
    end
  end

  assign start_o    = (ph_q == PH_NOTIFY) && ack_i;
  assign fanout_o   = (ph_q == PH_FANOUT);
  assign clr_pend_o = (ph_q == PH_STALL) && (abort_i || force_i);
  assign clr_err_o  = (ph_q == PH_STALL) && abort_i;

  assign notify_o   = (ph_q == PH_NOTIFY);
  assign all_done_o = (ph_q == PH_READY);
  assign slot_pwr_o = (ph_q != PH_OFF);
  assign busy_o     = (ph_q != PH_IDLE) && (ph_q != PH_OFF);

  always_comb begin
    unique case (ph_q)
      PH_IDLE: led_o = IND_STEDY;
      PH_OFF:  led_o = IND_DARK;
      default: led_o = IND_BLINK;
    endcase
  end

  // R8: a halted removal holds until the manager intervenes
  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STALL && !abort_i && !force_i) |=> (ph_q == PH_STALL));

  // R6: once powered off the slot stays off
  p_off_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OFF) |=> (ph_q == PH_OFF));

endmodule

// File: rtl/hot_removal_seq.sv
module hot_removal_seq #(
  parameter int NUM_PLANES = 4,
  parameter int TMO_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  attn_press_i,
  input  logic [NUM_PLANES-1:0] plane_en_i,
  input  logic [TMO_W-1:0]      tmo_limit_i,
  output logic                  mgr_notify_o,
  input  logic                  mgr_notify_ack_i,
  output logic [NUM_PLANES-1:0] vevt_req_o,
  input  logic [NUM_PLANES-1:0] vevt_done_i,
  output logic                  mgr_all_done_o,
  input  logic                  mgr_power_off_i,
  input  logic                  mgr_abort_i,
  input  logic                  mgr_force_i,
  output logic [NUM_PLANES-1:0] plane_err_o,
  output logic                  slot_pwr_o,
  output logic [1:0]            led_o,
  output logic                  busy_o
);

  import hrs_pkg::*;

  logic                  start, fanout, clr_pend, clr_err, expire;
  logic [NUM_PLANES-1:0] pend, err;
  logic                  any_pend;

  assign any_pend = |pend;

  hrs_phys_fsm u_phys (
    .clk        (clk),
    .rst_n      (rst_n),
    .press_i    (attn_press_i),
    .ack_i      (mgr_notify_ack_i),
    .all_clear_i(!any_pend),
    .expire_i   (expire),
    .pwr_cmd_i  (mgr_power_off_i),
    .abort_i    (mgr_abort_i),
    .force_i    (mgr_force_i),
    .start_o    (start),
    .fanout_o   (fanout),
    .clr_pend_o (clr_pend),
    .clr_err_o  (clr_err),
    .notify_o   (mgr_notify_o),
    .all_done_o (mgr_all_done_o),
    .slot_pwr_o (slot_pwr_o),
    .led_o      (led_o),
    .busy_o     (busy_o)
  );

  hrs_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (fanout),
    .any_pend_i(any_pend),
    .limit_i   (tmo_limit_i),
    .expire_o  (expire)
  );

  for (genvar gi = 0; gi < NUM_PLANES; gi++) begin : g_plane
    hrs_vplane u_vplane (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (plane_en_i[gi]),
      .start_i   (start),
      .accept_i  (fanout),
      .done_i    (vevt_done_i[gi]),
      .expire_i  (expire),
      .clr_pend_i(clr_pend),
      .clr_err_i (clr_err),
      .pend_o    (pend[gi]),
      .err_o     (err[gi])
    );
  end

  assign vevt_req_o  = pend;
  assign plane_err_o = err;

  // R6: power only falls after all-done was shown and the command arrived
  p_pwr_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_pwr_o) |-> ($past(mgr_all_done_o) && $past(mgr_power_off_i)));

  // R6: no plane may still be pending when power is removed
  p_pwr_no_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_pwr_o) |-> ($past(vevt_req_o) == '0));

  // R2: notification is raised only by a button press
  p_notify_from_press_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgr_notify_o) |-> $past(attn_press_i));

  // R11: an unpowered slot shows a dark indicator
  p_dark_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_pwr_o |-> (led_o == IND_DARK));

  // R5: all-done never coexists with an outstanding plane request
  p_done_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_all_done_o |-> (vevt_req_o == '0));

endmodule

// File: tb/test_hot_removal_seq.sv
module test_hot_removal_seq;

  localparam int NP = 4;
  localparam int TW = 16;

  logic          clk;
  logic          rst_n;
  logic          attn;
  logic [NP-1:0] en;
  logic [TW-1:0] limit;
  logic          notify;
  logic          ack;
  logic [NP-1:0] req;
  logic [NP-1:0] done;
  logic          all_done;
  logic          pwr_cmd;
  logic          abort_c;
  logic          force_c;
  logic [NP-1:0] err;
  logic          pwr;
  logic [1:0]    led;
  logic          busy;

  hot_removal_seq #(.NUM_PLANES(NP), .TMO_W(TW)) i_hot_removal_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .attn_press_i    (attn),
    .plane_en_i      (en),
    .tmo_limit_i     (limit),
    .mgr_notify_o    (notify),
    .mgr_notify_ack_i(ack),
    .vevt_req_o      (req),
    .vevt_done_i     (done),
    .mgr_all_done_o  (all_done),
    .mgr_power_off_i (pwr_cmd),
    .mgr_abort_i     (abort_c),
    .mgr_force_i     (force_c),
    .plane_err_o     (err),
    .slot_pwr_o      (pwr),
    .led_o           (led),
    .busy_o          (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string         tag;
    logic          notify;
    logic [NP-1:0] req;
    logic          all_done;
    logic          pwr;
    logic [1:0]    led;
    logic [NP-1:0] err;
    logic          busy;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // monitor: pop expectations and compare against the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (notify !== e.notify || req !== e.req || all_done !== e.all_done ||
            pwr !== e.pwr || led !== e.led || err !== e.err || busy !== e.busy) begin
          n_fail++;
          $display("FAIL %s: got notify=%b req=%b done=%b pwr=%b led=%b err=%b busy=%b, exp notify=%b req=%b done=%b pwr=%b led=%b err=%b busy=%b",
                   e.tag, notify, req, all_done, pwr, led, err, busy,
                   e.notify, e.req, e.all_done, e.pwr, e.led, e.err, e.busy);
        end
      end
    end
  end

  task automatic expect_out(string tag, logic n, logic [NP-1:0] r, logic d,
                            logic p, logic [1:0] l, logic [NP-1:0] e, logic b);
    exp_t x;
    x.tag = tag; x.notify = n; x.req = r; x.all_done = d;
    x.pwr = p; x.led = l; x.err = e; x.busy = b;
    exp_q.push_back(x);
    -> chk_ev;
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press();      attn = 1'b1;    tick(1); attn = 1'b0;    endtask
  task automatic give_ack();   ack = 1'b1;     tick(1); ack = 1'b0;     endtask
  task automatic power_off();  pwr_cmd = 1'b1; tick(1); pwr_cmd = 1'b0; endtask
  task automatic do_abort();   abort_c = 1'b1; tick(1); abort_c = 1'b0; endtask
  task automatic do_force();   force_c = 1'b1; tick(1); force_c = 1'b0; endtask
  task automatic complete(logic [NP-1:0] m); done = m; tick(1); done = '0; endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, exp run to end");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    attn = 0; ack = 0; done = '0; pwr_cmd = 0; abort_c = 0; force_c = 0;
    en = 4'b1011; limit = 16'd20; rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    expect_out("R1 reset", 0, 4'b0000, 0, 1, 2'b01, 4'b0000, 0);

    // full removal with planes 0,1,3 enabled
    press();
    expect_out("R2 press notifies", 1, 4'b0000, 0, 1, 2'b10, 4'b0000, 1);
    press();
    expect_out("R7 press while notifying", 1, 4'b0000, 0, 1, 2'b10, 4'b0000, 1);
    give_ack();
    expect_out("R3 fan out to enabled", 0, 4'b1011, 0, 1, 2'b10, 4'b0000, 1);
    press();
    expect_out("R7 press while waiting", 0, 4'b1011, 0, 1, 2'b10, 4'b0000, 1);
    power_off();
    expect_out("R6 early power-off ignored", 0, 4'b1011, 0, 1, 2'b10, 4'b0000, 1);
    complete(4'b0001);
    expect_out("R4 plane0 completes", 0, 4'b1010, 0, 1, 2'b10, 4'b0000, 1);
    complete(4'b1010);
    expect_out("R5 not yet done", 0, 4'b0000, 0, 1, 2'b10, 4'b0000, 1);
    tick(1);
    expect_out("R5 all done", 0, 4'b0000, 1, 1, 2'b10, 4'b0000, 1);
    power_off();
    expect_out("R6 power removed R11", 0, 4'b0000, 0, 0, 2'b00, 4'b0000, 0);
    press();
    tick(2);
    expect_out("R6 stays off", 0, 4'b0000, 0, 0, 2'b00, 4'b0000, 0);

    // timeout then abort
    en = 4'b0110; limit = 16'd5;
    do_reset();
    press();
    give_ack();
    expect_out("R3 fan out planes 1,2", 0, 4'b0110, 0, 1, 2'b10, 4'b0000, 1);
    complete(4'b0010);
    expect_out("R4 plane1 completes", 0, 4'b0100, 0, 1, 2'b10, 4'b0000, 1);
    tick(4);
    expect_out("R8 before limit", 0, 4'b0100, 0, 1, 2'b10, 4'b0000, 1);
    tick(1);
    expect_out("R8 timeout flags plane2", 0, 4'b0100, 0, 1, 2'b10, 4'b0100, 1);
    tick(3);
    expect_out("R8 halted holds", 0, 4'b0100, 0, 1, 2'b10, 4'b0100, 1);
    do_abort();
    expect_out("R9 abort restores R11", 0, 4'b0000, 0, 1, 2'b01, 4'b0000, 0);

    // restart after abort, no planes enabled
    en = 4'b0000;
    press();
    expect_out("R9 restart notifies", 1, 4'b0000, 0, 1, 2'b10, 4'b0000, 1);
    give_ack();
    expect_out("R3 nothing enabled", 0, 4'b0000, 0, 1, 2'b10, 4'b0000, 1);
    tick(1);
    expect_out("R5 empty set done", 0, 4'b0000, 1, 1, 2'b10, 4'b0000, 1);

    // timeout then force
    en = 4'b1001; limit = 16'd3;
    do_reset();
    press();
    give_ack();
    tick(3);
    expect_out("R8 at limit no error yet", 0, 4'b1001, 0, 1, 2'b10, 4'b0000, 1);
    tick(1);
    expect_out("R8 timeout flags 0,3", 0, 4'b1001, 0, 1, 2'b10, 4'b1001, 1);
    complete(4'b0001);
    expect_out("R8 completion ignored when halted", 0, 4'b1001, 0, 1, 2'b10, 4'b1001, 1);
    power_off();
    expect_out("R6 power-off ignored when halted", 0, 4'b1001, 0, 1, 2'b10, 4'b1001, 1);
    do_force();
    expect_out("R10 force completes", 0, 4'b0000, 1, 1, 2'b10, 4'b1001, 1);
    power_off();
    expect_out("R10 power removed", 0, 4'b0000, 0, 0, 2'b00, 4'b1001, 0);

    tick(1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule